// File: doc/BRIEF.md
# Tile background pixel generator

This block turns tile pattern data into one background colour per dot for a tile-based video controller. A fetch sequencer outside the block supplies, once per 8-dot tile, a low bitplane byte, a high bitplane byte and a 2-bit palette group. The bytes go into a staging register. Four 16-bit shifters, one each for the two pattern planes and the two attribute bits, take the staged tile when their 8th advance comes round. The block therefore always holds the current tile and the next one, so a fine horizontal scroll of up to seven pixels can read ahead into the next tile.

On every active dot the block selects one shifter tap using a 3-bit fine-X value. It forms a 2-bit pixel value and a 5-bit palette index, then looks up a 6-bit colour in a 32-entry palette RAM and registers the result. The palette RAM has a simple write port. On that port, the transparent slot of each upper 4-colour group folds onto the matching lower slot. A small combinational helper also gives the pair of pattern-store addresses for a tile row, inside a 1 KB store that repeats across the whole pattern space.

Top module: `bg_pixel_gen`

## Requirements
- R1: After reset, `color_o` is 0x00 and every palette entry holds 0x00.
- R2: Pixels leave the shifters most-significant bit first. Pixel bit 0 comes from the low plane and bit 1 from the high plane. A low plane of 0x81 with a zero high plane gives the pixel values 1,0,0,0,0,0,0,1. With both planes at 0x81 the values are 3,0,0,0,0,0,0,3.
- R3: A non-zero pixel value p with palette group g reads palette entry {0, g[1:0], p[1:0]}, which is below 0x10. For example, p=1 with g=0 reads entry 0x01.
- R4: A pixel value of 0 reads palette entry 0x00 whatever its palette group.
- R5: Palette writes to addresses 0x10, 0x14, 0x18 and 0x1C store into entries 0x00, 0x04, 0x08 and 0x0C. Every other address stores into its own entry, so a write to 0x11 leaves the colour of entry 0x01 unchanged.
- R6: The tiles are taken as one pixel stream, with pixel 0 being the MSB of the first primed tile. With fine-X = f, the colour on visible dot v (counted from 0) comes from stream pixel v+f, for any f in 0..7.
- R7: Each dot with `render_en_i` and `shift_en_i` high advances the shifters by one bit. On every 8th such dot after reset, the shifters reload from the tile last captured by `tile_wr_i`. A capture on the reload dot itself does not feed that reload. Two tiles of 8 advances each prime a line.
- R8: `color_o` is registered. It updates on the edge of the dot it belongs to. It is 0x00 after any edge where `visible_i` was low, such as the pre-render line or the prefetch dots.
- R9: While `render_en_i` is low, `color_o` goes to 0x00 and the shifters and dot phase hold their values, even if `shift_en_i` is high.
- R10: For tile index t and row r, `pat_lo_addr_o` = {t[5:0], 0, r[2:0]} and `pat_hi_addr_o` = {t[5:0], 1, r[2:0]}, which is 8 higher. Tile index bits 7:6 are ignored because the 1 KB store repeats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Dot clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| render_en_i | input | 1 | Background rendering enabled |
| shift_en_i | input | 1 | Dot advances the shifters |
| visible_i | input | 1 | Dot lies in the visible region |
| fine_x_i | input | 3 | Fine horizontal scroll, shifter tap select |
| tile_wr_i | input | 1 | Capture next tile into staging register |
| tile_lo_i | input | 8 | Low bitplane byte of next tile row |
| tile_hi_i | input | 8 | High bitplane byte of next tile row |
| tile_attr_i | input | 2 | Palette group of next tile |
| pal_we_i | input | 1 | Palette write strobe |
| pal_addr_i | input | 5 | Palette write address |
| pal_data_i | input | 6 | Palette write colour |
| tile_idx_i | input | 8 | Tile index for address formation |
| row_i | input | 3 | Row within tile for address formation |
| pat_lo_addr_o | output | 10 | Low bitplane byte address |
| pat_hi_addr_o | output | 10 | High bitplane byte address |
| color_o | output | 6 | Registered colour index |

## Verification
The assertions assume that the fetch sequencer keeps to whole 8-dot groups. They also assume that a tile is captured at least one dot before the reload that should use it, and that a capture is never placed on a reload dot if that reload expects the new tile. The stimulus respects this. It starts every line at phase zero after reset and primes with exactly two 8-dot groups. It writes each staged tile on the first dot of a group and shifts in multiples of eight. It holds fine-X steady through a line, and it writes the palette only outside active dots. The backdrop check keeps its own copy of entry 0x00, so it relies on no palette write landing on the same dot as a transparent-pixel lookup.

// File: rtl/bg_pkg.sv
package bg_pkg;
  localparam int PAL_AW  = 5;
  localparam int COLOR_W = 6;

  typedef logic [PAL_AW-1:0] pal_addr_t;

  // transparent slots of the upper groups share the lower slot
  function automatic pal_addr_t pal_fold(input pal_addr_t a);
    pal_addr_t r;
    r = a;
    if (a[4] && a[1:0] == 2'b00) r[4] = 1'b0;
    return r;
  endfunction
endpackage

// File: rtl/bg_shifter.sv
module bg_shifter #(
  parameter int TILE_W = 8,
  parameter int SEL_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              adv_i,
  input  logic              reload_i,
  input  logic [TILE_W-1:0] fill_i,
  input  logic [SEL_W-1:0]  sel_i,
  output logic              tap_o,
  output logic [2*TILE_W-1:0] word_o
);
  localparam int SH_W = 2 * TILE_W;

  logic [SH_W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q <= '0;
    end else if (adv_i) begin
      if (reload_i) q <= {q[SH_W-2:TILE_W-1], fill_i};
      else          q <= {q[SH_W-2:0], 1'b0};
    end
  end

  assign tap_o  = q[SH_W-1-int'(sel_i)];
  assign word_o = q;
endmodule

// File: rtl/bg_palette.sv
module bg_palette
  import bg_pkg::*;
#(
  parameter int AW = PAL_AW,
  parameter int DW = COLOR_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  pal_addr_t     wa;

  assign wa = pal_fold(pal_addr_t'(waddr_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we_i) begin
      mem[wa] <= wdata_i;
    end
  end

  assign rdata_o = mem[pal_fold(pal_addr_t'(raddr_i))];
endmodule

// File: rtl/bg_pat_addr.sv
module bg_pat_addr #(
  parameter int TID_W  = 8,
  parameter int ROW_W  = 3,
  parameter int PAT_AW = 10
) (
  input  logic [TID_W-1:0]  tile_idx_i,
  input  logic [ROW_W-1:0]  row_i,
  output logic [PAT_AW-1:0] lo_o,
  output logic [PAT_AW-1:0] hi_o
);
  localparam int KEEP = PAT_AW - ROW_W - 1;

  // upper tile bits fall outside the mirrored store
  assign lo_o = {tile_idx_i[KEEP-1:0], 1'b0, row_i};
  assign hi_o = {tile_idx_i[KEEP-1:0], 1'b1, row_i};
endmodule

// File: rtl/bg_pixel_gen.sv
module bg_pixel_gen
  import bg_pkg::*;
#(
  parameter int TILE_W = 8,
  parameter int TID_W  = 8,
  parameter int PAT_AW = 10
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     render_en_i,
  input  logic                     shift_en_i,
  input  logic                     visible_i,
  input  logic [$clog2(TILE_W)-1:0] fine_x_i,
  input  logic                     tile_wr_i,
  input  logic [TILE_W-1:0]        tile_lo_i,
  input  logic [TILE_W-1:0]        tile_hi_i,
  input  logic [1:0]               tile_attr_i,
  input  logic                     pal_we_i,
  input  logic [PAL_AW-1:0]        pal_addr_i,
  input  logic [COLOR_W-1:0]       pal_data_i,
  input  logic [TID_W-1:0]         tile_idx_i,
  input  logic [$clog2(TILE_W)-1:0] row_i,
  output logic [PAT_AW-1:0]        pat_lo_addr_o,
  output logic [PAT_AW-1:0]        pat_hi_addr_o,
  output logic [COLOR_W-1:0]       color_o
);
  localparam int PH_W   = $clog2(TILE_W);
  localparam int SH_W   = 2 * TILE_W;
  localparam int PLANES = 4;

  logic [TILE_W-1:0] stage_lo_q, stage_hi_q;
  logic [1:0]        stage_at_q;
  logic [PH_W-1:0]   phase_q;
  logic              adv, reload;
  logic [TILE_W-1:0] fill [PLANES];
  logic [PLANES-1:0] tap;
  logic [SH_W-1:0]   word [PLANES];
  logic [1:0]        bg_pix, bg_grp;
  logic [PAL_AW-1:0] rd_idx;
  logic [COLOR_W-1:0] rd_color, color_q;

  assign adv    = render_en_i & shift_en_i;
  assign reload = adv && (phase_q == PH_W'(TILE_W-1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_lo_q <= '0;
      stage_hi_q <= '0;
      stage_at_q <= '0;
    end else if (tile_wr_i) begin
      stage_lo_q <= tile_lo_i;
      stage_hi_q <= tile_hi_i;
      stage_at_q <= tile_attr_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  phase_q <= '0;
    else if (adv) phase_q <= phase_q + 1'b1;
  end

  assign fill[0] = stage_lo_q;
  assign fill[1] = stage_hi_q;
  assign fill[2] = {TILE_W{stage_at_q[0]}};
  assign fill[3] = {TILE_W{stage_at_q[1]}};

  for (genvar g = 0; g < PLANES; g++) begin : g_plane
    bg_shifter #(.TILE_W(TILE_W), .SEL_W(PH_W)) u_sh (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .adv_i   (adv),
      .reload_i(reload),
      .fill_i  (fill[g]),
      .sel_i   (fine_x_i),
      .tap_o   (tap[g]),
      .word_o  (word[g])
    );
  end

  assign bg_pix = {tap[1], tap[0]};
  assign bg_grp = {tap[3], tap[2]};
  assign rd_idx = (bg_pix == 2'b00) ? '0 : {1'b0, bg_grp, bg_pix};

  bg_palette #(.AW(PAL_AW), .DW(COLOR_W)) u_pal (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (pal_we_i),
    .waddr_i(pal_addr_i),
    .wdata_i(pal_data_i),
    .raddr_i(rd_idx),
    .rdata_o(rd_color)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       color_q <= '0;
    else if (render_en_i && visible_i) color_q <= rd_color;
    else                               color_q <= '0;
  end

  assign color_o = color_q;

  bg_pat_addr #(.TID_W(TID_W), .ROW_W(PH_W), .PAT_AW(PAT_AW)) u_addr (
    .tile_idx_i(tile_idx_i),
    .row_i     (row_i),
    .lo_o      (pat_lo_addr_o),
    .hi_o      (pat_hi_addr_o)
  );
endmodule

// File: rtl/bg_pixel_gen_chk.sv
module bg_pixel_gen_chk #(
  parameter int TILE_W  = 8,
  parameter int PAT_AW  = 10,
  parameter int PAL_AW  = 5,
  parameter int COLOR_W = 6
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      render_en_i,
  input logic                      shift_en_i,
  input logic                      visible_i,
  input logic                      pal_we_i,
  input logic [PAL_AW-1:0]         pal_addr_i,
  input logic [COLOR_W-1:0]        pal_data_i,
  input logic [$clog2(TILE_W)-1:0] row_i,
  input logic [PAT_AW-1:0]         pat_lo_addr_o,
  input logic [PAT_AW-1:0]         pat_hi_addr_o,
  input logic [COLOR_W-1:0]        color_o,
  input logic [$clog2(TILE_W)-1:0] phase_i,
  input logic [1:0]                pix_i,
  input logic [TILE_W-1:0]         stage_lo_i,
  input logic [2*TILE_W-1:0]       sh_lo_i
);
  localparam int RW = $clog2(TILE_W);

  logic [COLOR_W-1:0] bd_q;

  // own copy of the shared backdrop entry
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bd_q <= '0;
    else if (pal_we_i && pal_addr_i[3:0] == 4'h0) bd_q <= pal_data_i;
  end

  // R8
  visible_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !visible_i |=> color_o == '0);

  // R9
  render_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !render_en_i |=> color_o == '0);

  // R9
  frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !render_en_i |=> $stable(phase_i) && $stable(sh_lo_i));

  // R7
  reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (render_en_i && shift_en_i && phase_i == RW'(TILE_W-1))
      |=> sh_lo_i[TILE_W-1:0] == $past(stage_lo_i));

  // R4
  backdrop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (render_en_i && visible_i && pix_i == 2'b00 && !pal_we_i)
      |=> color_o == $past(bd_q));

  // R10
  pat_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pat_lo_addr_o[RW] && pat_hi_addr_o[RW] && pat_lo_addr_o[RW-1:0] == row_i
      && pat_hi_addr_o[PAT_AW-1:RW+1] == pat_lo_addr_o[PAT_AW-1:RW+1]);
endmodule

bind bg_pixel_gen bg_pixel_gen_chk #(
  .TILE_W(TILE_W), .PAT_AW(PAT_AW), .PAL_AW(bg_pkg::PAL_AW), .COLOR_W(bg_pkg::COLOR_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .render_en_i  (render_en_i),
  .shift_en_i   (shift_en_i),
  .visible_i    (visible_i),
  .pal_we_i     (pal_we_i),
  .pal_addr_i   (pal_addr_i),
  .pal_data_i   (pal_data_i),
  .row_i        (row_i),
  .pat_lo_addr_o(pat_lo_addr_o),
  .pat_hi_addr_o(pat_hi_addr_o),
  .color_o      (color_o),
  .phase_i      (phase_q),
  .pix_i        (bg_pix),
  .stage_lo_i   (stage_lo_q),
  .sh_lo_i      (word[0])
);

// File: tb/bg_pixel_gen_bench.sv
`timescale 1ns/1ps
module bg_pixel_gen_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       render_en = 1'b0, shift_en = 1'b0, visible = 1'b0;
  logic [2:0] fine_x = '0;
  logic       tile_wr = 1'b0;
  logic [7:0] tile_lo = '0, tile_hi = '0;
  logic [1:0] tile_attr = '0;
  logic       pal_we = 1'b0;
  logic [4:0] pal_addr = '0;
  logic [5:0] pal_data = '0;
  logic [7:0] tile_idx = '0;
  logic [2:0] row = '0;
  logic [9:0] pat_lo_addr, pat_hi_addr;
  logic [5:0] color;

  int vecs = 0;
  int miscmp = 0;

  logic [5:0] pal_m [32];
  logic [7:0] lo_t [4];
  logic [7:0] hi_t [4];
  logic [1:0] at_t [4];

  always #2.5 clk = ~clk;

  bg_pixel_gen u_bg_pixel_gen (
    .clk_i(clk), .rst_ni(rst_n), .render_en_i(render_en), .shift_en_i(shift_en),
    .visible_i(visible), .fine_x_i(fine_x), .tile_wr_i(tile_wr), .tile_lo_i(tile_lo),
    .tile_hi_i(tile_hi), .tile_attr_i(tile_attr), .pal_we_i(pal_we), .pal_addr_i(pal_addr),
    .pal_data_i(pal_data), .tile_idx_i(tile_idx), .row_i(row),
    .pat_lo_addr_o(pat_lo_addr), .pat_hi_addr_o(pat_hi_addr), .color_o(color)
  );

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    vecs++;
    if (got !== exp) begin
      miscmp++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  function automatic logic [4:0] fold(input logic [4:0] a);
    return (a[4] && a[1:0] == 2'b00) ? {1'b0, a[3:0]} : a;
  endfunction

  task automatic pal_write(input logic [4:0] a, input logic [5:0] d);
    pal_we = 1'b1; pal_addr = a; pal_data = d;
    @(posedge clk); #1;
    pal_we = 1'b0;
    pal_m[fold(a)] = d;
  endtask

  // one dot: optional tile capture, sample after the edge
  task automatic dot(input logic sh, input logic vis, input int wr_tile);
    shift_en = sh; visible = vis;
    tile_wr = (wr_tile >= 0);
    if (wr_tile >= 0) begin
      tile_lo = lo_t[wr_tile]; tile_hi = hi_t[wr_tile]; tile_attr = at_t[wr_tile];
    end
    @(posedge clk); #1;
    tile_wr = 1'b0; shift_en = 1'b0; visible = 1'b0;
  endtask

  function automatic logic [5:0] exp_color(input int s);
    int t, b;
    logic [1:0] p;
    logic [4:0] idx;
    t = s / 8; b = 7 - (s % 8);
    p = {hi_t[t][b], lo_t[t][b]};
    idx = (p == 2'b00) ? 5'h00 : {1'b0, at_t[t], p};
    return pal_m[idx];
  endfunction

  task automatic run_line(input logic [2:0] fx, input string tag);
    int bad;
    bad = 0;
    fine_x = fx;
    render_en = 1'b1;
    for (int d = 0; d < 16; d++) begin
      dot(1'b1, 1'b0, (d == 0) ? 0 : (d == 8) ? 1 : -1);
      if (color !== 6'h00) bad++;
    end
    vecs++;
    if (bad != 0) begin
      miscmp++;
      $display("FAIL R8 %s prefetch: got %0d nonzero expected 0", tag, bad);
    end
    for (int v = 0; v < 16; v++) begin
      dot(1'b1, 1'b1, (v == 0) ? 2 : (v == 8) ? 3 : -1);
      check($sformatf("%s dot %0d", tag, v), 16'(color), 16'(exp_color(v + int'(fx))));
    end
  endtask

  task automatic set_tiles(input logic [7:0] l0, l1, l2, l3, h0, h1, h2, h3,
                           input logic [1:0] a0, a1, a2, a3);
    lo_t[0] = l0; lo_t[1] = l1; lo_t[2] = l2; lo_t[3] = l3;
    hi_t[0] = h0; hi_t[1] = h1; hi_t[2] = h2; hi_t[3] = h3;
    at_t[0] = a0; at_t[1] = a1; at_t[2] = a2; at_t[3] = a3;
  endtask

  task automatic t_reset();
    check("R1 reset colour", 16'(color), 16'h0);
    for (int i = 0; i < 32; i++) pal_m[i] = 6'h00;
    render_en = 1'b1;
    set_tiles(8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 2'd3, 2'd3, 2'd3, 2'd3);
    run_line(3'd0, "R1 palette cleared");
  endtask

  task automatic t_pal_init();
    for (int i = 0; i < 32; i++) pal_write(5'(i), 6'((i * 7 + 5) & 63));
  endtask

  task automatic t_msb_first();
    set_tiles(8'h81, 8'h81, 8'h81, 8'h81, 8'h00, 8'h00, 8'h00, 8'h00, 2'd0, 2'd0, 2'd0, 2'd0);
    run_line(3'd0, "R2 R3 lo=81");
    check("R3 entry 01 colour", 16'(pal_m[1]), 16'(6'((1 * 7 + 5) & 63)));
  endtask

  task automatic t_both_planes();
    set_tiles(8'h81, 8'h81, 8'h81, 8'h81, 8'h81, 8'h81, 8'h81, 8'h81, 2'd2, 2'd2, 2'd2, 2'd2);
    run_line(3'd0, "R2 lo=hi=81 grp2");
  endtask

  task automatic t_groups();
    set_tiles(8'hF0, 8'h0F, 8'hAA, 8'h55, 8'h3C, 8'hC3, 8'h66, 8'h99, 2'd0, 2'd1, 2'd2, 2'd3);
    run_line(3'd0, "R3 R4 group mix");
  endtask

  task automatic t_fine_x();
    set_tiles(8'hE1, 8'h35, 8'h9C, 8'h0F, 8'h47, 8'hB8, 8'h2D, 8'hF0, 2'd1, 2'd3, 2'd0, 2'd2);
    run_line(3'd3, "R6 fx=3");
    run_line(3'd7, "R6 fx=7");
    run_line(3'd1, "R6 fx=1");
  endtask

  task automatic t_mirror();
    pal_write(5'h10, 6'h2A);
    pal_write(5'h11, 6'h3F);
    pal_write(5'h1C, 6'h15);
    check("R5 0x10 folds to 0x00", 16'(pal_m[0]), 16'h2A);
    set_tiles(8'h81, 8'h81, 8'h81, 8'h81, 8'h00, 8'h00, 8'h00, 8'h00, 2'd3, 2'd0, 2'd3, 2'd0);
    run_line(3'd0, "R5 backdrop via 0x10, entry 01 kept");
  endtask

  task automatic t_render_off();
    int bad;
    bad = 0;
    render_en = 1'b0;
    for (int d = 0; d < 13; d++) begin
      dot(1'b1, 1'b1, -1);
      if (color !== 6'h00) bad++;
    end
    vecs++;
    if (bad != 0) begin
      miscmp++;
      $display("FAIL R9 render off: got %0d nonzero expected 0", bad);
    end
    set_tiles(8'hC3, 8'h18, 8'h7E, 8'h01, 8'h0F, 8'hF0, 8'h81, 8'h80, 2'd2, 2'd1, 2'd3, 2'd0);
    run_line(3'd2, "R9 phase held while off");
  endtask

  task automatic t_pat_addr();
    tile_idx = 8'h00; row = 3'd0; #1;
    check("R10 lo t00 r0", 16'(pat_lo_addr), 16'h000);
    check("R10 hi t00 r0", 16'(pat_hi_addr), 16'h008);
    tile_idx = 8'h45; row = 3'd5; #1;
    check("R10 lo t45 r5", 16'(pat_lo_addr), 16'h055);
    check("R10 hi t45 r5", 16'(pat_hi_addr), 16'h05D);
    tile_idx = 8'hC5; row = 3'd5; #1;
    check("R10 lo tC5 mirrors", 16'(pat_lo_addr), 16'h055);
    tile_idx = 8'h3F; row = 3'd7; #1;
    check("R10 hi t3F r7", 16'(pat_hi_addr), 16'h3FF);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    vecs++;
    miscmp++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miscmp);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    t_reset();
    t_pal_init();
    t_msb_first();
    t_both_planes();
    t_groups();
    t_fine_x();
    t_mirror();
    t_render_off();
    t_pat_addr();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miscmp);
    $finish;
  end
endmodule